// File: doc/BRIEF.md
# Deep-Sleep Pad Output Override

This block sits on the path from the output multiplexer to the pads. While the chip is awake, each pad's value and output enable pass straight through from the multiplexer. When the power controller raises the sleep request, every pad whose current output source may enter low power is forced to a programmed sleep behaviour. The behaviour is chosen per pad from four options: drive low, drive high, float, or hold whatever the pad was driving when sleep began.

Whether a pad can be overridden depends on what its output select currently points at. The constant and float codes can always sleep. A peripheral output can sleep only if its bit is set in an elaboration-time mask. Pads fed by an always-on peripheral keep their normal output through sleep. Some pads are built with no sleep register at all. On those pads the register ignores writes, reads as zero, and is never overridden. The sleep registers are written and read through a simple indexed port.

Top module: `pad_sleep_override`

## Requirements
- R1: After reset, every implemented sleep register reads 2 (float), and the pads follow the multiplexer.
- R2: When the sleep request was low at the previous clock edge, every pad's value and enable equal the multiplexer's value and enable.
- R3: In sleep, an eligible pad follows its sleep code. Code 0 gives value 0 with enable 1. Code 1 gives value 1 with enable 1. Code 2 gives value 0 with enable 0.
- R4: With code 3 (keep), an eligible pad holds the value and enable the multiplexer presented at the clock edge where the sleep request was first seen high. A float state is held as float. The held state lasts for the whole sleep period, whatever the multiplexer does.
- R5: Output select codes 0 (constant low), 1 (constant high) and 2 (float) are always eligible for override.
- R6: Output select code 3+k names peripheral k. That pad is eligible when bit k of the peripheral sleep mask is 1.
- R7: The pad keeps its multiplexer output during sleep when its select names an always-on peripheral (mask bit 0). The same holds for a select code of 3+NPeriph or above.
- R8: A pad whose bit in the pad sleep mask is 0 ignores register writes, reads 0, and is never overridden.
- R9: The override begins one clock edge after the sleep request rises. The multiplexer output returns one clock edge after the sleep request falls.
- R10: On an implemented pad, a write stores the 2-bit code, and the read port returns the code of the pad that the index selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_en_i | input | 1 | Sleep request from the power controller |
| mux_out_i | input | NPads | Multiplexed pad values |
| mux_oe_i | input | NPads | Multiplexed pad output enables |
| out_sel_i | input | NPads*SelW | Per-pad output select codes, pad p at bits [p*SelW +: SelW] |
| cfg_we_i | input | 1 | Sleep register write strobe |
| cfg_idx_i | input | IdxW | Pad index for write and read |
| cfg_wdata_i | input | 2 | Sleep code to write |
| cfg_rdata_o | output | 2 | Sleep code of the indexed pad |
| pad_out_o | output | NPads | Final pad values |
| pad_oe_o | output | NPads | Final pad output enables |

## Verification
The assertions are checked on every cycle. They cover:
- pass-through while awake;
- pass-through on pads without a sleep register, and the zero read-back of those registers;
- float on eligible pads programmed with code 2;
- stability of a held pad through sleep.

Only the bench scenarios can show some behaviours. These are:
- the exact values captured at the rising edge of sleep;
- the one-edge delay at entry and exit;
- how each select code class maps to eligibility;
- the reset value of the registers.

// File: rtl/pad_sleep_override.sv
module pad_sleep_override #(
  parameter int NPads = 8,
  parameter int NPeriph = 6,
  parameter logic [NPeriph-1:0] PeriphSleepable = 6'b101111,
  parameter logic [NPads-1:0] PadSleepable = 8'b0111_1111,
  parameter int SelW = $clog2(NPeriph + 3),
  parameter int IdxW = (NPads > 1) ? $clog2(NPads) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sleep_en_i,
  input  logic [NPads-1:0]      mux_out_i,
  input  logic [NPads-1:0]      mux_oe_i,
  input  logic [NPads*SelW-1:0] out_sel_i,
  input  logic                  cfg_we_i,
  input  logic [IdxW-1:0]       cfg_idx_i,
  input  logic [1:0]            cfg_wdata_i,
  output logic [1:0]            cfg_rdata_o,
  output logic [NPads-1:0]      pad_out_o,
  output logic [NPads-1:0]      pad_oe_o
);
  localparam int NCodes = 2 ** SelW;
  localparam logic [1:0] CodeLow  = 2'd0;
  localparam logic [1:0] CodeHigh = 2'd1;
  localparam logic [1:0] CodeHiZ  = 2'd2;
  localparam logic [1:0] CodeKeep = 2'd3;

  logic             sleep_q;
  logic [NPads-1:0] keep_out_q, keep_oe_q;
  logic [1:0]       cfg_q [NPads];
  logic [NCodes-1:0] code_ok;
  logic [NPads-1:0] elig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_q    <= 1'b0;
      keep_out_q <= '0;
      keep_oe_q  <= '0;
    end else begin
      sleep_q <= sleep_en_i;
      if (sleep_en_i && !sleep_q) begin
        keep_out_q <= mux_out_i;
        keep_oe_q  <= mux_oe_i;
      end
    end
  end

  for (genvar c = 0; c < NCodes; c++) begin : g_code
    if (c < 3) begin : g_fixed
      assign code_ok[c] = 1'b1;
    end else if (c - 3 < NPeriph) begin : g_periph
      assign code_ok[c] = PeriphSleepable[c-3];
    end else begin : g_unused
      assign code_ok[c] = 1'b0;
    end
  end

  always_comb begin
    cfg_rdata_o = 2'b00;
    if (int'(cfg_idx_i) < NPads) cfg_rdata_o = cfg_q[cfg_idx_i];
  end

  for (genvar p = 0; p < NPads; p++) begin : g_pad
    logic [SelW-1:0] sel;
    logic            ovr_out, ovr_oe;
    assign sel = out_sel_i[p*SelW +: SelW];

    if (PadSleepable[p]) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q[p] <= CodeHiZ;
        else if (cfg_we_i && int'(cfg_idx_i) == p) cfg_q[p] <= cfg_wdata_i;
      end
      assign elig[p] = code_ok[sel];
    end else begin : g_noreg
      assign cfg_q[p] = 2'b00;
      assign elig[p]  = 1'b0;
    end

    always_comb begin
      unique case (cfg_q[p])
        CodeLow:  begin ovr_out = 1'b0;          ovr_oe = 1'b1;         end
        CodeHigh: begin ovr_out = 1'b1;          ovr_oe = 1'b1;         end
        CodeHiZ:  begin ovr_out = 1'b0;          ovr_oe = 1'b0;         end
        default:  begin ovr_out = keep_out_q[p]; ovr_oe = keep_oe_q[p]; end
      endcase
    end

    assign pad_out_o[p] = (sleep_q && elig[p]) ? ovr_out : mux_out_i[p];
    assign pad_oe_o[p]  = (sleep_q && elig[p]) ? ovr_oe  : mux_oe_i[p];

    AST_HIZ_FLOATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sleep_q && elig[p] && cfg_q[p] == CodeHiZ) |-> !pad_oe_o[p]); // R3

    AST_KEEP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sleep_q && $past(sleep_q) && elig[p] && $past(elig[p])
       && cfg_q[p] == CodeKeep && $past(cfg_q[p]) == CodeKeep)
      |-> ($stable(pad_out_o[p]) && $stable(pad_oe_o[p]))); // R4
  end

  AST_AWAKE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_q |-> (pad_out_o == mux_out_i && pad_oe_o == mux_oe_i)); // R2

  AST_NOREG_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o & ~PadSleepable) == (mux_out_i & ~PadSleepable))
    && ((pad_oe_o & ~PadSleepable) == (mux_oe_i & ~PadSleepable))); // R8

  AST_NOREG_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cfg_idx_i) < NPads && !PadSleepable[cfg_idx_i]) |-> cfg_rdata_o == 2'b00); // R8
endmodule

// File: tb/tb_pad_sleep_override.sv
module tb_pad_sleep_override;
  localparam int NPads = 8;
  localparam int SelW = 4;
  localparam int IdxW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_en = 1'b0;
  logic [NPads-1:0] mux_out = '0, mux_oe = '0;
  logic [NPads*SelW-1:0] sel = '0;
  logic cfg_we = 1'b0;
  logic [IdxW-1:0] cfg_idx = '0;
  logic [1:0] cfg_wdata = '0;
  logic [1:0] cfg_rdata;
  logic [NPads-1:0] pad_out, pad_oe;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pad_sleep_override dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_en_i(sleep_en),
    .mux_out_i(mux_out), .mux_oe_i(mux_oe), .out_sel_i(sel),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .pad_out_o(pad_out), .pad_oe_o(pad_oe));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_sel(int p, int code);
    sel[p*SelW +: SelW] = SelW'(code);
  endtask

  task automatic wr(int p, logic [1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IdxW'(p); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(string req, int p, logic [1:0] exp);
    cfg_idx = IdxW'(p);
    #1;
    check(req, 32'(cfg_rdata), 32'(exp));
  endtask

  task automatic t_reset;
    for (int p = 0; p < 7; p++) rd_check("R1 reset code", p, 2'd2);
    mux_out = 8'hA5; mux_oe = 8'h3C;
    #1;
    check("R1 reset pass out", 32'(pad_out), 32'h A5);
    check("R1 reset pass oe", 32'(pad_oe), 32'h3C);
  endtask

  task automatic t_regs;
    wr(3, 2'd0); wr(4, 2'd1); wr(5, 2'd2); wr(6, 2'd0); wr(2, 2'd0);
    rd_check("R10 readback p3", 3, 2'd0);
    rd_check("R10 readback p4", 4, 2'd1);
    wr(7, 2'd1);
    rd_check("R8 no-reg read zero", 7, 2'd0);
  endtask

  task automatic t_modes;
    @(negedge clk);
    set_sel(3, 0); set_sel(4, 1); set_sel(5, 2); set_sel(6, 3 + 5);
    set_sel(2, 3 + 4); set_sel(7, 3);
    mux_out = 8'hFF; mux_oe = 8'hFF;
    sleep_en = 1'b1;
    #1;
    check("R9 no override before edge", 32'(pad_out), 32'hFF);
    @(negedge clk);
    check("R3/R5 code0 p3 out", 32'(pad_out[3]), 0);
    check("R3/R5 code0 p3 oe", 32'(pad_oe[3]), 1);
    check("R3/R5 code1 p4 out", 32'(pad_out[4]), 1);
    check("R3/R5 code2 p5 oe", 32'(pad_oe[5]), 0);
    check("R3/R5 code2 p5 out", 32'(pad_out[5]), 0);
    check("R6 sleepable periph p6 out", 32'(pad_out[6]), 0);
    check("R7 always-on periph p2 out", 32'(pad_out[2]), 1);
    check("R8 no-reg pad p7 out", 32'(pad_out[7]), 1);
    set_sel(2, 3 + 6);
    #1;
    check("R7 out-of-range sel p2 out", 32'(pad_out[2]), 1);
    sleep_en = 1'b0;
    #1;
    check("R9 still overridden before wake edge", 32'(pad_out[3]), 0);
    @(negedge clk);
    check("R2/R9 passthrough after wake", 32'(pad_out), 32'hFF);
  endtask

  task automatic t_keep;
    wr(0, 2'd3); wr(1, 2'd3);
    @(negedge clk);
    set_sel(0, 3); set_sel(1, 2);
    mux_out = 8'b0000_0001; mux_oe = 8'b0000_0001;
    sleep_en = 1'b1;
    @(negedge clk);
    mux_out = 8'b0000_0010; mux_oe = 8'b0000_0010;
    #1;
    check("R4 keep p0 out", 32'(pad_out[0]), 1);
    check("R4 keep p0 oe", 32'(pad_oe[0]), 1);
    check("R4 keep hiz p1 oe", 32'(pad_oe[1]), 0);
    repeat (3) @(negedge clk);
    check("R4 keep held p0 out", 32'(pad_out[0]), 1);
    check("R4 keep held p1 oe", 32'(pad_oe[1]), 0);
    sleep_en = 1'b0;
    @(negedge clk);
    check("R9 keep released p0", 32'(pad_out[0]), 0);
    check("R9 keep released p1 oe", 32'(pad_oe[1]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_modes();
    t_keep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule